// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block is a register-mapped real-time clock. A wide seconds counter advances by one each time the one-second tick input pulses while counting is on. Software presets the counter through a load register. The preset waits until the next counted tick before it takes effect. An alarm compares the counter with a match register and raises a sticky pending flag. That flag drives a single level interrupt output, gated by an enable bit and a mask bit.

Software reaches the block through a plain word-addressed read/write strobe bus. Read data is combinational from the address while the read strobe is high. One register clears the pending alarm as a side effect of being read. Raw and gated views of the alarm are kept in separate status registers. The tick comes from an external clock-enable source. There is no oscillator, no clock-domain crossing and no calendar logic in the block.

Top module: `secs_rtc`

## Requirements
- R1: After reset the counter, match, load and control registers read 0. Both status registers read 0 and `irq` is low.
- R2: Control bit 2 (count enable) turns counting on. While it is 1, each cycle with `tick_en` high advances the counter by one. The counter never changes on a cycle without `tick_en`.
- R3: A write to the load register (word 2) reads back at once, but the counter keeps its value until the next counted tick. That tick copies the load value into the counter in place of the increment.
- R4: While count enable is 0, ticks leave the counter unchanged, keep a written load pending and never raise the alarm.
- R5: With control bit 3 (wrap enable) at 1, a counted tick at 0xFFFFFFFF gives 0.
- R6: With wrap enable at 0, a counted tick at 0xFFFFFFFF leaves the counter at 0xFFFFFFFF.
- R7: A counted tick that gives the counter the value of the match register (word 1) sets the pending flag. Raw status (word 5) bit 0 shows the flag whatever the enable and mask bits are.
- R8: `irq` is the pending flag AND control bit 0 (interrupt enable) AND NOT control bit 1 (interrupt mask). Masked status (word 4) bit 0 equals `irq`.
- R9: Reading word 6 returns 0 and clears the pending flag. Reads of other registers leave the flag set.
- R10: Word 7 returns the `VERSION` parameter (default 0x00010200). Writes to it have no effect.
- R11: Words 8 to 15 read 0, and writes to them change no register. Writes to the counter (word 0) are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle pulse once per second |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (4) | Word index of the register |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data, valid while `rd_en` is high |
| irq | output | 1 | Level alarm interrupt |

## Verification
The assertions assume that `tick_en` is a single-cycle pulse and that it is the only cause of counter motion. They also assume that a read and a write never share a cycle. The stimulus keeps to this: every bus access and every tick is one strobe driven on a falling edge and dropped on the next. Ticks are never issued together with an end-of-interrupt read, so the set-versus-clear race is left out of the clearing property. The saturate and wrap properties rely on the counter reaching all ones, so the stimulus gets there through the load register instead of counting up.

// File: rtl/secs_rtc_pkg.sv
`timescale 1ns/1ps
package secs_rtc_pkg;
   // word index of each register; the software map depends on these
   typedef enum logic [2:0] {
      SEL_COUNT = 3'd0,
      SEL_MATCH = 3'd1,
      SEL_LOAD  = 3'd2,
      SEL_CTRL  = 3'd3,
      SEL_MSTAT = 3'd4,
      SEL_RSTAT = 3'd5,
      SEL_EOI   = 3'd6,
      SEL_VER   = 3'd7
   } reg_sel_e;

   // control bits, msb first: wrap, count enable, mask, interrupt enable
   typedef struct packed {
      logic wrap_en;
      logic cnt_en;
      logic irq_mask;
      logic irq_en;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/secs_rtc_regs.sv
`timescale 1ns/1ps
module secs_rtc_regs
   import secs_rtc_pkg::*;
#(
   parameter int DW = 32,
   parameter int CNT_W = 32,
   parameter int ADDR_W = 4,
   parameter logic [DW-1:0] VERSION = 32'h0001_0200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              flag,
   input  logic              irq,
   input  logic              load_take,
   output logic [DW-1:0]     rdata,
   output logic [CNT_W-1:0]  match,
   output logic [CNT_W-1:0]  load_val,
   output logic              load_pend,
   output ctrl_t             ctrl,
   output logic              eoi_rd
);
   localparam int PAD_W = DW - CNT_W;

   logic      mapped;
   reg_sel_e  sel;
   logic      wr_hit;
   logic [DW-1:0] cnt_x, match_x, load_x;

   assign mapped = (addr[ADDR_W-1:3] == '0);
   assign sel    = reg_sel_e'(addr[2:0]);
   assign wr_hit = wr_en & mapped;
   assign eoi_rd = rd_en & mapped & (sel == SEL_EOI);

   generate
      if (PAD_W == 0) begin : g_nopad
         assign cnt_x   = cnt;
         assign match_x = match;
         assign load_x  = load_val;
      end else begin : g_pad
         assign cnt_x   = {{PAD_W{1'b0}}, cnt};
         assign match_x = {{PAD_W{1'b0}}, match};
         assign load_x  = {{PAD_W{1'b0}}, load_val};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match     <= '0;
         load_val  <= '0;
         load_pend <= 1'b0;
         ctrl      <= '0;
      end else begin
         if (wr_hit && sel == SEL_MATCH) match <= wdata[CNT_W-1:0];
         if (wr_hit && sel == SEL_CTRL)  ctrl  <= ctrl_t'(wdata[CTRL_W-1:0]);
         if (wr_hit && sel == SEL_LOAD) begin
            load_val  <= wdata[CNT_W-1:0];
            load_pend <= 1'b1;
         end else if (load_take) begin
            load_pend <= 1'b0;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_en && mapped) begin
         case (sel)
            SEL_COUNT: rdata = cnt_x;
            SEL_MATCH: rdata = match_x;
            SEL_LOAD:  rdata = load_x;
            SEL_CTRL:  rdata = {{(DW-CTRL_W){1'b0}}, ctrl};
            SEL_MSTAT: rdata = {{(DW-1){1'b0}}, irq};
            SEL_RSTAT: rdata = {{(DW-1){1'b0}}, flag};
            SEL_VER:   rdata = VERSION;
            default:   rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/secs_rtc_count.sv
`timescale 1ns/1ps
module secs_rtc_count #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_en,
   input  logic             wrap_en,
   input  logic             load_pend,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] match,
   output logic [CNT_W-1:0] cnt,
   output logic             load_take,
   output logic             hit
);
   logic             step;
   logic [CNT_W-1:0] nxt;

   assign step      = tick & cnt_en;
   assign load_take = step & load_pend;

   always_comb begin
      if (load_pend)           nxt = load_val;
      else if (cnt == '1)      nxt = wrap_en ? '0 : cnt;
      else                     nxt = cnt + 1'b1;
   end

   // compare the value being taken, so the flag rises with the counter
   assign hit = step & (nxt == match);

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (step) cnt <= nxt;
   end
endmodule

// File: rtl/secs_rtc_irq.sv
`timescale 1ns/1ps
module secs_rtc_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic eoi_rd,
   input  logic irq_en,
   input  logic irq_mask,
   output logic flag,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n)      flag <= 1'b0;
      else if (hit)    flag <= 1'b1;
      else if (eoi_rd) flag <= 1'b0;
   end

   assign irq = flag & irq_en & ~irq_mask;
endmodule

// File: rtl/secs_rtc.sv
`timescale 1ns/1ps
module secs_rtc
   import secs_rtc_pkg::*;
#(
   parameter int DW = 32,
   parameter int CNT_W = 32,
   parameter int ADDR_W = 4,
   parameter logic [DW-1:0] VERSION = 32'h0001_0200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   output logic              irq
);
   generate
      if (CNT_W > DW || CNT_W < 1) begin : g_bad_cnt
         $error("secs_rtc: CNT_W must lie in 1..DW");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("secs_rtc: ADDR_W must be at least 4");
      end
      if (DW < CTRL_W) begin : g_bad_dw
         $error("secs_rtc: DW too narrow for control");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q, match_q, load_q;
   logic             load_pend, load_take, alarm_hit, alarm_flag, eoi_rd;
   ctrl_t            ctrl;

   secs_rtc_regs #(.DW(DW), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .VERSION(VERSION)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .cnt(cnt_q), .flag(alarm_flag), .irq(irq),
      .load_take(load_take), .rdata(rdata), .match(match_q), .load_val(load_q),
      .load_pend(load_pend), .ctrl(ctrl), .eoi_rd(eoi_rd)
   );

   secs_rtc_count #(.CNT_W(CNT_W)) count_i (
      .clk(clk), .rst_n(rst_n), .tick(tick_en), .cnt_en(ctrl.cnt_en),
      .wrap_en(ctrl.wrap_en), .load_pend(load_pend), .load_val(load_q),
      .match(match_q), .cnt(cnt_q), .load_take(load_take), .hit(alarm_hit)
   );

   secs_rtc_irq irq_i (
      .clk(clk), .rst_n(rst_n), .hit(alarm_hit), .eoi_rd(eoi_rd),
      .irq_en(ctrl.irq_en), .irq_mask(ctrl.irq_mask), .flag(alarm_flag), .irq(irq)
   );
endmodule

// File: rtl/secs_rtc_chk.sv
`timescale 1ns/1ps
module secs_rtc_chk #(
   parameter int CNT_W = 32,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic              irq,
   input logic [CNT_W-1:0]  cnt,
   input logic              flag,
   input logic              load_pend,
   input logic              cnt_en,
   input logic              wrap_en
);
   logic counted;
   assign counted = tick_en & cnt_en & ~load_pend;

   assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(cnt));

   assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (counted && cnt != '1) |=> cnt == CNT_W'($past(cnt) + 1'b1));

   assert_load_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load_pend && !cnt_en) |=> load_pend);

   assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (counted && wrap_en && cnt == '1) |=> cnt == '0);

   assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (counted && !wrap_en && cnt == '1) |=> cnt == '1);

   assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);

   assert_eoi_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == ADDR_W'(6) && !(tick_en && cnt_en)) |=> (!flag && !irq));
endmodule

bind secs_rtc secs_rtc_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rd_en(rd_en), .addr(addr),
   .irq(irq), .cnt(cnt_q), .flag(alarm_flag), .load_pend(load_pend),
   .cnt_en(ctrl.cnt_en), .wrap_en(ctrl.wrap_en)
);

// File: tb/secs_rtc_tb.sv
`timescale 1ns/1ps
module secs_rtc_tb_top;
   localparam logic [31:0] VER = 32'h0001_0200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   secs_rtc dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(posedge clk); @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic tick();
      tick_en = 1'b1;
      @(posedge clk); @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic expect_reg(input string req, input logic [3:0] a, input logic [31:0] exp);
      logic [31:0] d;
      reg_rd(a, d);
      check(req, d, exp);
   endtask

   task automatic t_reset();
      expect_reg("R1 counter", 4'd0, 32'h0);
      expect_reg("R1 match", 4'd1, 32'h0);
      expect_reg("R1 load", 4'd2, 32'h0);
      expect_reg("R1 control", 4'd3, 32'h0);
      expect_reg("R1 masked status", 4'd4, 32'h0);
      expect_reg("R1 raw status", 4'd5, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);
      expect_reg("R10 version", 4'd7, VER);
   endtask

   task automatic t_disabled();
      tick();
      expect_reg("R4 disabled tick", 4'd0, 32'h0);
      reg_wr(4'd2, 32'd5);
      expect_reg("R3 load readback", 4'd2, 32'd5);
      tick(); tick();
      expect_reg("R4 load held while disabled", 4'd0, 32'h0);
      expect_reg("R4 no alarm while disabled", 4'd5, 32'h0);
      reg_wr(4'd1, 32'd100);
      reg_wr(4'd3, 32'h4);
      expect_reg("R3 no change before tick", 4'd0, 32'h0);
      tick();
      expect_reg("R3 load taken at tick", 4'd0, 32'd5);
   endtask

   task automatic t_count();
      tick();
      expect_reg("R2 step 1", 4'd0, 32'd6);
      repeat (5) @(negedge clk);
      expect_reg("R2 idle no change", 4'd0, 32'd6);
      tick(); tick();
      expect_reg("R2 step 2", 4'd0, 32'd8);
      reg_wr(4'd2, 32'd40);
      tick();
      expect_reg("R3 load beats increment", 4'd0, 32'd40);
   endtask

   task automatic t_wrap();
      reg_wr(4'd3, 32'hC);
      reg_wr(4'd2, 32'hFFFF_FFFE);
      tick(); tick();
      expect_reg("R5 at max", 4'd0, 32'hFFFF_FFFF);
      tick();
      expect_reg("R5 wrap to zero", 4'd0, 32'h0);
      reg_wr(4'd3, 32'h4);
      reg_wr(4'd2, 32'hFFFF_FFFF);
      tick(); tick(); tick();
      expect_reg("R6 saturate", 4'd0, 32'hFFFF_FFFF);
   endtask

   task automatic t_alarm();
      logic [31:0] d;
      reg_rd(4'd6, d);
      reg_wr(4'd1, 32'd10);
      reg_wr(4'd3, 32'h5);
      reg_wr(4'd2, 32'd8);
      tick(); tick();
      expect_reg("R7 no alarm before match", 4'd5, 32'h0);
      check("R8 irq low before match", {31'b0, irq}, 32'h0);
      tick();
      expect_reg("R7 raw set on match", 4'd5, 32'h1);
      expect_reg("R8 masked status", 4'd4, 32'h1);
      check("R8 irq high", {31'b0, irq}, 32'h1);
      expect_reg("R9 raw kept after other reads", 4'd5, 32'h1);
      reg_rd(4'd6, d);
      check("R9 eoi reads zero", d, 32'h0);
      expect_reg("R9 raw cleared", 4'd5, 32'h0);
      check("R9 irq cleared", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_mask();
      logic [31:0] d;
      reg_wr(4'd3, 32'h7);
      reg_wr(4'd1, 32'd21);
      reg_wr(4'd2, 32'd20);
      tick(); tick();
      expect_reg("R7 raw set while masked", 4'd5, 32'h1);
      expect_reg("R8 masked status low", 4'd4, 32'h0);
      check("R8 irq masked", {31'b0, irq}, 32'h0);
      reg_wr(4'd3, 32'h5);
      check("R8 irq after unmask", {31'b0, irq}, 32'h1);
      reg_wr(4'd3, 32'h4);
      check("R8 irq with enable off", {31'b0, irq}, 32'h0);
      expect_reg("R8 masked status enable off", 4'd4, 32'h0);
      reg_rd(4'd6, d);
      expect_reg("R9 raw cleared after mask test", 4'd5, 32'h0);
   endtask

   task automatic t_unmapped();
      reg_wr(4'd0, 32'h1234);
      expect_reg("R11 counter write ignored", 4'd0, 32'd21);
      reg_wr(4'd7, 32'hDEAD_BEEF);
      expect_reg("R10 version write ignored", 4'd7, VER);
      reg_wr(4'd11, 32'h0);
      expect_reg("R11 alias write ignored", 4'd3, 32'h4);
      reg_wr(4'd8, 32'hFFFF_FFFF);
      expect_reg("R11 unmapped read 8", 4'd8, 32'h0);
      expect_reg("R11 unmapped read 15", 4'd15, 32'h0);
      expect_reg("R11 match untouched", 4'd1, 32'd21);
   endtask

   initial begin
      #200000000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_count();
      t_wrap();
      t_alarm();
      t_mask();
      t_unmapped();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule